// File: doc/BRIEF.md
# Programmable Panel Strobe Generator

This block produces one control strobe for a display panel. Its position comes from the line and pixel counters that the rest of the timing controller already runs. A vertical window selects a band of lines, given as a first line and a length in lines. A horizontal window selects a span of pixels, given as a first pixel and a length counted in pairs of pixel clocks. The strobe is active where the two windows overlap. A length of zero turns that window into a permanent pass. One control bit moves the horizontal window one pixel later.

An alternating mode turns the strobe into an inversion-style signal. The window result is gated by a phase bit. This bit flips at the first pixel of every line. Each frame-start pulse flips the phase that the frame begins with. A polarity bit inverts the final level. The output is registered, so it reflects the counter values presented one clock earlier. Several strobes are built by instantiating the block several times. Each instance takes its configuration from outside.

Top module: `panel_strobe_gen`

## Requirements
- R1: With a nonzero vertical length `cfg_vlen`, the vertical window is active exactly for lines `cfg_vfirst` through `cfg_vfirst + cfg_vlen - 1`.
- R2: A vertical length of zero makes the vertical window active on every line.
- R3: With a nonzero horizontal length `cfg_hlen`, the horizontal window is active exactly for pixel counts `cfg_hfirst` through `cfg_hfirst + 2*cfg_hlen - 1`.
- R4: A horizontal length of zero makes the horizontal window active on every pixel.
- R5: When `cfg_hshift` is 1, the horizontal window starts and ends one pixel count later than with `cfg_hshift` at 0.
- R6: The active level is the AND of the two windows. `strobe_o` shows the result for the counter values sampled at one rising edge, from that edge until the next one.
- R7: When `cfg_invert` is 1, `strobe_o` is the complement of the active level, so its inactive level is 1.
- R8: When `cfg_alt_en` is 1, the active level is the window result ANDed with a line phase bit. The phase bit inverts on every clock where `pix_cnt` is 0 and `frame_start` is 0.
- R9: On a clock with `frame_start` at 1, the frame phase inverts. The line phase for that clock takes the new frame phase value, so successive frames start on opposite phases.
- R10: While `rst_n` is 0 at a rising edge, `strobe_o` takes the value of `cfg_invert` and both phase bits clear to 0, whatever the counters are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-clock pulse at the first pixel of a frame |
| line_cnt | input | 11 | Current line number |
| pix_cnt | input | 12 | Current pixel count within the line |
| cfg_vfirst | input | 11 | First line of the vertical window |
| cfg_vlen | input | 11 | Vertical window length in lines, 0 means always on |
| cfg_hfirst | input | 10 | First pixel count of the horizontal window |
| cfg_hlen | input | 11 | Horizontal window length in pixel pairs, 0 means always on |
| cfg_hshift | input | 1 | Delays the horizontal window by one pixel |
| cfg_invert | input | 1 | Output polarity, 1 means active low |
| cfg_alt_en | input | 1 | Enables the line/frame alternating mode |
| strobe_o | output | 1 | Registered strobe |

## Verification
The embedded properties assume several things about the inputs. `frame_start` is at most a single-clock pulse. A new line is marked only by `pix_cnt` returning to 0. Configuration inputs hold steady for at least one clock around each compared sample, because the polarity checks compare against the configuration of the previous clock. The directed stimulus respects these points. It changes configuration only between scenarios and raises `frame_start` only on clocks with `pix_cnt` at 0. Each scenario then steps the counters through the window edges: one before, on, at the last active position and one past.

// File: rtl/strobe_pkg.sv
// Package strobe_pkg
// Shared widths, the output-mode type and small helper functions for the
// panel strobe generator. Assumes nothing beyond IEEE 1800-2017.
package strobe_pkg;

    // Default counter and field widths used by the top level.
    localparam int LINE_W_DEF   = 11;
    localparam int PIX_W_DEF    = 12;
    localparam int HFIRST_W_DEF = 10;
    localparam int LEN_W_DEF    = 11;

    // How the window result is turned into an active level.
    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_ALT   = 1'b1
    } strobe_mode_t;

    // Larger of two widths, used to size comparison arithmetic.
    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/span_window.sv
// Module span_window
// Combinational window test: active when position lies in
// [first, first + len*2^LEN_SHIFT), or always when len is zero.
// Optional one-step delay of the first position (HAS_DELAY).
// Assumes that first, len and pos are unsigned. All arithmetic is widened
// so that no sum can wrap.
module span_window
    import strobe_pkg::*;
#(
    parameter int POS_W     = 11,
    parameter int FIRST_W   = 11,
    parameter int LEN_W     = 11,
    parameter int LEN_SHIFT = 0,
    parameter bit HAS_DELAY = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [POS_W-1:0]   pos,
    input  logic [FIRST_W-1:0] first,
    input  logic [LEN_W-1:0]   len,
    input  logic               delay_en,
    output logic               active
);

    // One extra bit for the delay, one for the sum of first and span.
    localparam int SPAN_W = LEN_W + LEN_SHIFT;
    localparam int SUM_W  = wmax(wmax(POS_W, FIRST_W), SPAN_W) + 2;

    logic [SUM_W-1:0] pos_x;
    logic [SUM_W-1:0] first_x;
    logic [SUM_W-1:0] span_x;
    logic [SUM_W-1:0] end_x;
    logic             len_zero;
    logic             at_or_after;
    logic             before_end;

    // Pick the starting position variant chosen by the parameter.
    generate
        if (HAS_DELAY) begin : g_delay
            always_comb first_x = SUM_W'(first) + SUM_W'(delay_en);
        end else begin : g_plain
            always_comb first_x = SUM_W'(first);
        end
    endgenerate

    // Widen the position and scale the length into position units.
    always_comb begin
        pos_x  = SUM_W'(pos);
        span_x = SUM_W'(len) << LEN_SHIFT;
        end_x  = first_x + span_x;
    end

    // Bound comparisons and the zero-length bypass.
    always_comb begin
        len_zero    = (len == '0);
        at_or_after = (pos_x >= first_x);
        before_end  = (pos_x < end_x);
        active      = len_zero | (at_or_after & before_end);
    end

    // Window checks against inputs (R1/R3 lower bound, R2/R4 bypass).
    assert_lower_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((len != '0) && (SUM_W'(pos) < SUM_W'(first))) |-> !active)
        else $error("window active before its first position");

    assert_zero_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (len == '0) |-> active)
        else $error("zero-length window not always on");

endmodule

// File: rtl/alt_phase.sv
// Module alt_phase
// Tracks the line phase and the frame phase for the alternating mode.
// The line phase inverts when a new line begins. A frame start inverts the
// frame phase and loads it into the line phase. phase_o is the phase that
// applies to the current clock's pixel.
// Assumes frame_start is a single-clock pulse. When both events coincide,
// frame_start takes priority.
module alt_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic line_begin,
    output logic phase_o
);

    logic line_ph_q;
    logic frame_ph_q;
    logic frame_ph_nxt;

    // Next frame phase: invert on frame start, otherwise hold.
    always_comb frame_ph_nxt = frame_start ? ~frame_ph_q : frame_ph_q;

    // Phase for the current pixel, with frame start taking priority.
    always_comb begin
        if (frame_start)
            phase_o = frame_ph_nxt;
        else if (line_begin)
            phase_o = ~line_ph_q;
        else
            phase_o = line_ph_q;
    end

    // Store both phases; synchronous active-low reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_ph_q  <= 1'b0;
            frame_ph_q <= 1'b0;
        end else begin
            line_ph_q  <= phase_o;
            frame_ph_q <= frame_ph_nxt;
        end
    end

    // Frame start flips the frame phase.
    assert_frame_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (frame_ph_q != $past(frame_ph_q)))
        else $error("frame phase did not invert");

    // A new line flips the line phase.
    assert_line_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_begin && !frame_start) |=> (line_ph_q != $past(line_ph_q)))
        else $error("line phase did not invert at line start");

    // With no event the line phase holds.
    assert_line_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_begin && !frame_start) |=> $stable(line_ph_q))
        else $error("line phase moved without an event");

endmodule

// File: rtl/panel_strobe_gen.sv
// Module panel_strobe_gen
// One programmable panel strobe. The vertical and horizontal span windows
// are ANDed, optionally gated by the alternating phase, and polarity is
// applied. The result is registered.
// Assumes that the counters come from the shared timing counters, that a
// line begins when pix_cnt is 0, and that configuration is quasi-static.
module panel_strobe_gen
    import strobe_pkg::*;
#(
    parameter int LINE_W   = LINE_W_DEF,
    parameter int PIX_W    = PIX_W_DEF,
    parameter int HFIRST_W = HFIRST_W_DEF,
    parameter int LEN_W    = LEN_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic [LINE_W-1:0]   line_cnt,
    input  logic [PIX_W-1:0]    pix_cnt,
    input  logic [LINE_W-1:0]   cfg_vfirst,
    input  logic [LEN_W-1:0]    cfg_vlen,
    input  logic [HFIRST_W-1:0] cfg_hfirst,
    input  logic [LEN_W-1:0]    cfg_hlen,
    input  logic                cfg_hshift,
    input  logic                cfg_invert,
    input  logic                cfg_alt_en,
    output logic                strobe_o
);

    logic         v_active;
    logic         h_active;
    logic         line_begin;
    logic         phase;
    logic         both;
    logic         level;
    strobe_mode_t mode;
    logic         strobe_q;

    // Vertical band: lines, length in lines, no delay option.
    span_window #(
        .POS_W     (LINE_W),
        .FIRST_W   (LINE_W),
        .LEN_W     (LEN_W),
        .LEN_SHIFT (0),
        .HAS_DELAY (1'b0)
    ) u_vwin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (line_cnt),
        .first    (cfg_vfirst),
        .len      (cfg_vlen),
        .delay_en (1'b0),
        .active   (v_active)
    );

    // Horizontal span: pixel counts, length in pixel pairs, delayable.
    span_window #(
        .POS_W     (PIX_W),
        .FIRST_W   (HFIRST_W),
        .LEN_W     (LEN_W),
        .LEN_SHIFT (1),
        .HAS_DELAY (1'b1)
    ) u_hwin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (pix_cnt),
        .first    (cfg_hfirst),
        .len      (cfg_hlen),
        .delay_en (cfg_hshift),
        .active   (h_active)
    );

    // Line start marker for the phase tracker.
    always_comb line_begin = (pix_cnt == '0);

    // Alternating phase tracker.
    alt_phase u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_begin  (line_begin),
        .phase_o     (phase)
    );

    // Combine the windows, apply the mode gating, then the polarity.
    always_comb begin
        mode = cfg_alt_en ? MODE_ALT : MODE_PLAIN;
        both = v_active & h_active;
        case (mode)
            MODE_ALT: level = both & phase;
            default:  level = both;
        endcase
    end

    // Output register; reset drives the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= cfg_invert;
        else
            strobe_q <= level ^ cfg_invert;
    end

    always_comb strobe_o = strobe_q;

    // Both windows open in plain mode give the active level one clock later.
    assert_and_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_alt_en && v_active && h_active) |=> (strobe_o == ~$past(cfg_invert)))
        else $error("strobe not active with both windows open");

    // A closed vertical window gives the inactive level.
    assert_v_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!v_active) |=> (strobe_o == $past(cfg_invert)))
        else $error("strobe active outside vertical window");

    // A closed horizontal window gives the inactive level.
    assert_h_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_active) |=> (strobe_o == $past(cfg_invert)))
        else $error("strobe active outside horizontal window");

    // In the alternating mode a zero phase keeps the output inactive.
    assert_alt_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_alt_en && !phase) |=> (strobe_o == $past(cfg_invert)))
        else $error("alternating strobe active on zero phase");

endmodule

// File: tb/sim_panel_strobe_gen.sv
`timescale 1ns/100ps
module sim_panel_strobe_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_start;
    logic [10:0] line_cnt;
    logic [11:0] pix_cnt;
    logic [10:0] cfg_vfirst;
    logic [10:0] cfg_vlen;
    logic [9:0]  cfg_hfirst;
    logic [10:0] cfg_hlen;
    logic        cfg_hshift;
    logic        cfg_invert;
    logic        cfg_alt_en;
    logic        strobe_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit m_lph    = 1'b0;
    bit m_fph    = 1'b0;

    always #2.5 clk = ~clk;

    panel_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_cnt(line_cnt), .pix_cnt(pix_cnt),
        .cfg_vfirst(cfg_vfirst), .cfg_vlen(cfg_vlen),
        .cfg_hfirst(cfg_hfirst), .cfg_hlen(cfg_hlen),
        .cfg_hshift(cfg_hshift), .cfg_invert(cfg_invert),
        .cfg_alt_en(cfg_alt_en), .strobe_o(strobe_o)
    );

    task automatic check(input bit act, input bit exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: strobe_o=%0b expected %0b (line %0d pix %0d)",
                     req, act, exp, line_cnt, pix_cnt);
        end
    endtask

    // Drive one counter sample, model the expected level, check after the edge.
    task automatic step(input int ln, input int px, input bit fs, input string req);
        bit vw, hw, lvl;
        int hs;
        @(negedge clk);
        line_cnt = 11'(ln); pix_cnt = 12'(px); frame_start = fs;
        if (fs) begin m_fph = ~m_fph; m_lph = m_fph; end
        else if (px == 0) m_lph = ~m_lph;
        vw = (cfg_vlen == 0) || (ln >= int'(cfg_vfirst) && ln < int'(cfg_vfirst) + int'(cfg_vlen));
        hs = int'(cfg_hfirst) + int'(cfg_hshift);
        hw = (cfg_hlen == 0) || (px >= hs && px < hs + 2 * int'(cfg_hlen));
        lvl = vw && hw;
        if (cfg_alt_en) lvl = lvl && m_lph;
        @(posedge clk); #1;
        check(strobe_o, lvl ^ cfg_invert, req);
        frame_start = 1'b0;
    endtask

    task automatic set_default();
        cfg_vfirst = 11'd10; cfg_vlen = 11'd3;
        cfg_hfirst = 10'd20; cfg_hlen = 11'd4;
        cfg_hshift = 1'b0; cfg_invert = 1'b0; cfg_alt_en = 1'b0;
    endtask

    // R10: reset dominates the counters and sets the inactive level.
    task automatic t_reset(input bit inv);
        @(negedge clk);
        cfg_invert = inv; rst_n = 1'b0;
        line_cnt = 11'd11; pix_cnt = 12'd22; frame_start = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check(strobe_o, inv, "R10 reset level");
        @(negedge clk);
        rst_n = 1'b1; m_lph = 1'b0; m_fph = 1'b0;
    endtask

    // R1/R6: vertical band edges with the horizontal window open.
    task automatic t_vertical();
        set_default();
        step(9, 22, 0, "R1 line before band");
        step(10, 22, 0, "R1 first line");
        step(12, 22, 0, "R1 last line");
        step(13, 22, 0, "R1 line after band");
    endtask

    // R2: zero vertical length passes every line.
    task automatic t_vzero();
        set_default(); cfg_vlen = 11'd0;
        step(500, 22, 0, "R2 far line");
        step(0, 22, 0, "R2 line zero");
    endtask

    // R3: horizontal span edges, length counted in pixel pairs.
    task automatic t_horizontal();
        set_default();
        step(11, 19, 0, "R3 before span");
        step(11, 20, 0, "R3 first pixel");
        step(11, 27, 0, "R3 last pixel");
        step(11, 28, 0, "R3 after span");
    endtask

    // R4/R6: zero horizontal length, still ANDed with the vertical band.
    task automatic t_hzero();
        set_default(); cfg_hlen = 11'd0;
        step(11, 1000, 0, "R4 far pixel");
        step(20, 1000, 0, "R6 vertical closed");
    endtask

    // R5: one-pixel delay moves both edges.
    task automatic t_shift();
        set_default(); cfg_hshift = 1'b1;
        step(11, 20, 0, "R5 old first pixel");
        step(11, 21, 0, "R5 delayed first pixel");
        step(11, 28, 0, "R5 delayed last pixel");
        step(11, 29, 0, "R5 after delayed span");
    endtask

    // R7: inverted polarity.
    task automatic t_polarity();
        set_default(); cfg_invert = 1'b1;
        step(11, 22, 0, "R7 active low inside");
        step(11, 5, 0, "R7 idle high outside");
    endtask

    // R8: alternating phase across several lines.
    task automatic t_alt();
        set_default(); cfg_alt_en = 1'b1; cfg_vlen = 11'd0; cfg_hlen = 11'd0;
        for (int ln = 0; ln < 4; ln++) begin
            step(ln, 0, 0, "R8 line start");
            step(ln, 7, 0, "R8 mid line");
        end
    endtask

    // R9: frame start loads the inverted frame phase.
    task automatic t_frame();
        set_default(); cfg_alt_en = 1'b1; cfg_vlen = 11'd0; cfg_hlen = 11'd0;
        for (int fr = 0; fr < 3; fr++) begin
            step(0, 0, 1, "R9 frame first pixel");
            step(0, 9, 0, "R9 frame first line");
            step(1, 0, 0, "R9 frame second line");
        end
    endtask

    initial begin
        rst_n = 1'b0; frame_start = 1'b0; line_cnt = '0; pix_cnt = '0;
        set_default();
        t_reset(1'b0);
        t_vertical();
        t_vzero();
        t_horizontal();
        t_hzero();
        t_shift();
        t_polarity();
        t_alt();
        t_frame();
        set_default();
        t_reset(1'b1);
        t_reset(1'b0);
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule